// File: doc/BRIEF.md
# Bidirectional Flag Pin Controller

This block runs a bank of general-purpose flag pins, sixteen by default. Every pin is set as an input or an output on its own. A single flag register holds one bit per pin. For an output pin the bit is the value that software drives onto the pin. For an input pin the bit is either a live copy of the synchronised pin level or a sticky record of an edge. Software can set, clear or toggle any subset of flag bits in one write, and every bit it does not name keeps its value.

Two independent interrupt lines are each formed from the flag register and their own mask. Each mask has a plain write view, a write-1-to-set view and a write-1-to-clear view. Each input pin can be sensitive to a level or to edges. In edge mode it can catch one chosen edge or both edges, and a polarity bit picks the active level or the active edge. Pin inputs pass through a two-flop synchroniser first. The host reaches the registers over a simple bus with a write strobe, a 4-bit address and a combinational read path.

Top module: `flag_gpio`

## Requirements
- R1: After reset, all configuration registers, masks and flags are zero, both interrupt lines are low, `pin_oe_o` is zero and `pin_o` is zero.
- R2: The direction register at address 4 makes pin i an output when bit i is 1. `pin_oe_o` equals that register, and `pin_o` shows the flag bit for output pins and 0 for input pins.
- R3: A write to address 0 loads the flag register. Writes to address 1 (set), 2 (clear) and 3 (toggle) change only the bits written as 1, and all other flag bits are left unchanged.
- R4: An input pin in level mode (sense bit at address 11 = 0) has flag = synchronised pin XOR polarity bit (address 13). A pin change is visible on the third rising clock edge after it is applied. Flag writes to such a pin have no effect.
- R5: An input pin in edge mode (sense = 1) with the both-edges bit (address 12) at 0 latches its flag on a rising edge when polarity is 0, or on a falling edge when polarity is 1. The opposite edge has no effect, and the flag stays set after the pin returns.
- R6: With the both-edges bit at 1, an edge-mode input latches its flag on either edge.
- R7: A write-1-to-clear (address 2) clears a latched edge flag. If an edge event arrives in the same cycle as the clear, the flag stays set.
- R8: `irq_o[k]` is high exactly when some flag bit is set whose bit in mask k is also set. The two lines are independent.
- R9: Mask 0 has its plain write view at address 5, its set view at address 6 and its clear view at address 7. Mask 1 uses addresses 8, 9 and 10 for the same views. A read of the plain-write address returns the mask.
- R10: Changes on an output pin's input never alter its flag. A flag bit that software writes on an output pin raises an interrupt when that pin is masked in.
- R11: A read of address 14 returns the synchronised pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Values driven to output pins |
| pin_oe_o | output | 16 | Output enable per pin |
| irq_o | output | 2 | Interrupt lines, one per mask set |

## Verification
The bench looks for set, clear or toggle writes that spill onto bits not named in the write. A design with that fault would corrupt neighbouring outputs. It checks that a single-edge pin ignores the opposite edge and keeps its flag after the pin falls back; a design that treated edge mode like level mode would drop the flag. It times a clear write to land in the same cycle as a new edge, where giving the clear priority would lose an event. It also checks that level-mode flags ignore writes, that pin activity on output pins leaves their flags alone, and that the two masks gate the two interrupt lines independently.

// File: rtl/flag_gpio_pkg.sv
package flag_gpio_pkg;
  localparam int ADDR_W       = 4;
  localparam int NUM_IRQ      = 2;
  localparam int A_FLAG       = 0;
  localparam int A_FLAG_SET   = 1;
  localparam int A_FLAG_CLR   = 2;
  localparam int A_FLAG_TGL   = 3;
  localparam int A_DIR        = 4;
  localparam int A_MASK_BASE  = 5;   // mask k: base+3k write, +1 set, +2 clear
  localparam int A_SENSE      = 11;
  localparam int A_BOTH       = 12;
  localparam int A_POL        = 13;
  localparam int A_PINS       = 14;
endpackage

// File: rtl/flag_gpio_sync.sv
module flag_gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/flag_gpio_detect.sv
module flag_gpio_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] level_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise       = sync_i[i] & ~prev_i[i];
    assign fall       = ~sync_i[i] & prev_i[i];
    assign event_o[i] = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
    assign level_o[i] = sync_i[i] ^ pol_i[i];
  end
endmodule

// File: rtl/flag_gpio_irq.sv
module flag_gpio_irq #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  assign mask_en = wr_i | set_i | clr_i;

  always_comb begin
    mask_d = mask_q;
    if (wr_i)  mask_d = wdata_i;
    if (set_i) mask_d = mask_q | wdata_i;
    if (clr_i) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(mask_q & flag_i);

  // R9: set view raises every named bit
  a_r9_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R9: clear view drops every named bit
  a_r9_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/flag_gpio.sv
module flag_gpio
  import flag_gpio_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int W = N_PINS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [W-1:0] dir_q, sense_q, both_q, pol_q, flag_q;
  logic [W-1:0] flag_d, sw_val;
  logic [W-1:0] sync_w, prev_w, ev_w, lvl_w;
  logic [NUM_IRQ-1:0][W-1:0] mask_w;

  logic wr_flag, wr_set, wr_clr, wr_tgl, wr_dir, wr_sense, wr_both, wr_pol;
  assign wr_flag  = bus_we_i && (bus_addr_i == ADDR_W'(A_FLAG));
  assign wr_set   = bus_we_i && (bus_addr_i == ADDR_W'(A_FLAG_SET));
  assign wr_clr   = bus_we_i && (bus_addr_i == ADDR_W'(A_FLAG_CLR));
  assign wr_tgl   = bus_we_i && (bus_addr_i == ADDR_W'(A_FLAG_TGL));
  assign wr_dir   = bus_we_i && (bus_addr_i == ADDR_W'(A_DIR));
  assign wr_sense = bus_we_i && (bus_addr_i == ADDR_W'(A_SENSE));
  assign wr_both  = bus_we_i && (bus_addr_i == ADDR_W'(A_BOTH));
  assign wr_pol   = bus_we_i && (bus_addr_i == ADDR_W'(A_POL));

  flag_gpio_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_int_n), .async_i(pin_i),
    .sync_o(sync_w), .prev_o(prev_w)
  );

  flag_gpio_detect #(.W(W)) u_detect (
    .sync_i(sync_w), .prev_i(prev_w), .pol_i(pol_q), .both_i(both_q),
    .event_o(ev_w), .level_o(lvl_w)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    localparam int BASE = A_MASK_BASE + 3 * k;
    flag_gpio_irq #(.W(W)) u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .wr_i   (bus_we_i && (bus_addr_i == ADDR_W'(BASE))),
      .set_i  (bus_we_i && (bus_addr_i == ADDR_W'(BASE + 1))),
      .clr_i  (bus_we_i && (bus_addr_i == ADDR_W'(BASE + 2))),
      .wdata_i(bus_wdata_i),
      .flag_i (flag_q),
      .mask_o (mask_w[k]),
      .irq_o  (irq_o[k])
    );
  end

  // flag next state: software view, then per-pin mode selection
  always_comb begin
    sw_val = flag_q;
    if (wr_flag) sw_val = bus_wdata_i;
    if (wr_set)  sw_val = flag_q | bus_wdata_i;
    if (wr_clr)  sw_val = flag_q & ~bus_wdata_i;
    if (wr_tgl)  sw_val = flag_q ^ bus_wdata_i;
    flag_d = (dir_q & sw_val)
           | (~dir_q & sense_q & (sw_val | ev_w))
           | (~dir_q & ~sense_q & lvl_w);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      flag_q  <= '0;
    end else begin
      if (wr_dir)   dir_q   <= bus_wdata_i;
      if (wr_sense) sense_q <= bus_wdata_i;
      if (wr_both)  both_q  <= bus_wdata_i;
      if (wr_pol)   pol_q   <= bus_wdata_i;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_addr_i))
      A_FLAG:          bus_rdata_o = flag_q;
      A_DIR:           bus_rdata_o = dir_q;
      A_MASK_BASE:     bus_rdata_o = mask_w[0];
      A_MASK_BASE + 3: bus_rdata_o = mask_w[1];
      A_SENSE:         bus_rdata_o = sense_q;
      A_BOTH:          bus_rdata_o = both_q;
      A_POL:           bus_rdata_o = pol_q;
      A_PINS:          bus_rdata_o = sync_w;
      default:         bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = flag_q & dir_q;
  assign pin_oe_o = dir_q;

  // R3: set view leaves unnamed output flags alone
  a_r3_set_untouched: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wr_set |=> (((flag_q ^ $past(flag_q)) & $past(dir_q) & ~$past(bus_wdata_i)) == '0));
  // R4: level-mode inputs track the detector level
  a_r4_level_follow: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    1'b1 |=> (($past(~dir_q & ~sense_q) & (flag_q ^ $past(lvl_w))) == '0));
  // R7: an edge event always lands, even against a clear
  a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((ev_w & ~dir_q & sense_q) != '0) |=> (($past(ev_w & ~dir_q & sense_q) & ~flag_q) == '0));
  // R10: output flags move only on bus writes
  a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !bus_we_i |=> (((flag_q ^ $past(flag_q)) & $past(dir_q)) == '0));
endmodule

// File: tb/flag_gpio_bench.sv
module flag_gpio_bench;
  logic        clk, rst_n, we;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata, pins, pout, poe;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  flag_gpio u_flag_gpio (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    addr = 4'(a); wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v);  chk("R1 flags", v, 16'h0);
    rd(4, v);  chk("R1 dir", v, 16'h0);
    chk("R1 irq", {14'h0, irq}, 16'h0);
    chk("R1 oe", poe, 16'h0);
    chk("R1 out", pout, 16'h0);
  endtask

  task automatic t_dir();
    wr(4, 16'h00FF);
    chk("R2 oe", poe, 16'h00FF);
    wr(0, 16'hFFFF);
    chk("R2 out masked by dir", pout, 16'h00FF);
  endtask

  task automatic t_w1m();
    wr(4, 16'hFFFF);
    wr(0, 16'h0F0F); chk("R3 plain write", pout, 16'h0F0F);
    wr(1, 16'h00F0); chk("R3 set view", pout, 16'h0FFF);
    wr(2, 16'h0F00); chk("R3 clear view", pout, 16'h00FF);
    wr(3, 16'h0101); chk("R3 toggle view", pout, 16'h01FE);
  endtask

  task automatic t_out_ignore();
    logic [15:0] v;
    pins = 16'hFFFF; settle();
    rd(0, v); chk("R10 pin ignored on outputs", v, 16'h01FE);
    wr(5, 16'h0002);
    chk("R10 software flag raises irq0", {15'h0, irq[0]}, 16'h1);
    chk("R8 irq1 independent", {15'h0, irq[1]}, 16'h0);
    wr(5, 16'h0000);
    wr(4, 16'h0000);
    pins = 16'h0000; settle();
  endtask

  task automatic t_level();
    logic [15:0] v;
    rd(0, v); chk("R4 inputs low", v, 16'h0);
    pins = 16'h0005; settle();
    rd(0, v); chk("R4 level follows pin", v, 16'h0005);
    wr(13, 16'h0001); @(negedge clk);
    rd(0, v); chk("R4 polarity inverts", v, 16'h0004);
    wr(2, 16'h0004); @(negedge clk);
    rd(0, v); chk("R4 clear ignored on level pin", v, 16'h0004);
    wr(13, 16'h0000);
    pins = 16'h0000; settle();
    rd(0, v); chk("R4 level returns low", v, 16'h0);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(11, 16'h00F0);
    wr(13, 16'h0020);
    pins = 16'h0030; settle();
    rd(0, v); chk("R5 rise latched, falling-only pin quiet", v, 16'h0010);
    pins = 16'h0000; settle();
    rd(0, v); chk("R5 flag held and fall latched", v, 16'h0030);
    wr(2, 16'h0010);
    rd(0, v); chk("R7 w1c clears edge flag", v, 16'h0020);
  endtask

  task automatic t_race_both();
    logic [15:0] v;
    wr(12, 16'h0040);
    pins = 16'h0040;
    repeat (2) @(negedge clk);
    wr(2, 16'h0040);
    rd(0, v); chk("R7 edge beats same-cycle clear", v, 16'h0060);
    wr(2, 16'h0040);
    rd(0, v); chk("R7 cleared after race", v, 16'h0020);
    pins = 16'h0000; settle();
    rd(0, v); chk("R6 falling edge caught in both mode", v, 16'h0060);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(5, 16'h0020);
    wr(9, 16'h0040);
    chk("R8 irq0 from bit5", {15'h0, irq[0]}, 16'h1);
    chk("R8 irq1 from bit6", {15'h0, irq[1]}, 16'h1);
    rd(5, v); chk("R9 mask0 readback", v, 16'h0020);
    rd(8, v); chk("R9 mask1 readback after set", v, 16'h0040);
    wr(2, 16'h0020);
    chk("R8 irq0 drops", {15'h0, irq[0]}, 16'h0);
    chk("R8 irq1 stays", {15'h0, irq[1]}, 16'h1);
    wr(10, 16'h0040);
    chk("R9 mask1 clear drops irq1", {15'h0, irq[1]}, 16'h0);
    wr(6, 16'h0001);
    rd(5, v); chk("R9 mask0 set view", v, 16'h0021);
    wr(7, 16'h0020);
    rd(5, v); chk("R9 mask0 clear view", v, 16'h0001);
  endtask

  task automatic t_pins();
    logic [15:0] v;
    pins = 16'hA5C3; settle();
    rd(14, v); chk("R11 pin readback", v, 16'hA5C3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; we = 0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dir();
    t_w1m();
    t_out_ignore();
    t_level();
    t_edge();
    t_race_both();
    t_irq();
    t_pins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule